// File: doc/BRIEF.md
# SIMD Byte-Permute Execution Unit

This unit executes two byte-shuffling operations of a 32-bit SIMD extension and owns the sixteen-entry extension register file they write. Entry 0 is a hard zero: it reads as zero and no write can reach it. Each cycle the unit may receive one 32-bit instruction word, together with a valid strobe and the value of a general-purpose operand. The unit decodes the word and performs at most one register write, which takes effect on the next rising clock edge.

The immediate-load operation builds a word from an 8-bit immediate. A 3-bit selector picks one of eight patterns: the byte alone in a single lane, the byte in the even lanes or in the odd lanes, the byte in all four lanes, or a sign-extended halfword copied into both halves. The byte-align operation joins two source registers end to end. It shifts the pair left by a whole number of bytes and keeps the upper word. That byte count comes from the low three bits of the general-purpose operand. Malformed immediate loads and undefined shift counts are dropped silently.

The instruction input has a valid strobe but no ready signal. The unit never applies back-pressure and accepts a word on every cycle in which `insn_valid` is high. A debug read port returns any register without delay.

Top module: `simd_perm_unit`

## Requirements
- R1: A synchronous reset clears all sixteen registers. Register 0 reads as zero at all times.
- R2: The sub-opcode is bits [20:18]. Value 1 is byte-align and value 3 is immediate-load. Every other value leaves all registers unchanged, and so does any word presented while `insn_valid` is low.
- R3: Immediate-load fields are: destination at bits [9:6], immediate byte at [17:10], pad at [22:21], pattern at [25:23]. Patterns 0, 1, 2 and 3 place the zero-extended byte in byte lane 0, 1, 2 or 3 respectively, and every other bit is zero. Lane k is bits [8k+7:8k].
- R4: Pattern 4 writes the byte into lanes 0 and 2. Pattern 5 writes it into lanes 1 and 3. Pattern 7 writes it into all four lanes. All other bits are zero.
- R5: Pattern 6 sign-extends the byte to 16 bits and writes that halfword into both bits [31:16] and bits [15:0].
- R6: An immediate-load with a nonzero pad field, or with destination 0, changes no register.
- R7: Byte-align fields are: destination at [9:6], source B at [13:10], source C at [17:14]. The count n is `gp_value[2:0]`, and higher operand bits are ignored. For n from 1 to 3 the result is (B << 8n) | (C >> (32-8n)).
- R8: For n = 0 the byte-align result is B. For n = 4 it is C.
- R9: For n = 5, 6 or 7, byte-align leaves the destination unchanged, unless R10 applies. A destination of 0 suppresses the write for every n.
- R10: If source B and source C are both register 0 and the destination is nonzero, byte-align clears the destination to zero for every n.
- R11: A write caused by an instruction accepted at one rising edge can be read on the debug port right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 32 | Instruction word |
| gp_value | input | 32 | General-purpose operand; bits [2:0] give the byte-align count |
| dbg_addr | input | 4 | Debug read address |
| dbg_data | output | 32 | Debug read data, combinational |

## Verification
The bench builds the unit with its default parameters: 32-bit data, sixteen registers and 8-bit lanes. These make every register address, all eight immediate patterns and all eight byte-align counts reachable from the instruction format. With them, the bench reaches the end cases of the funnel (n of 0 and 4), the undefined counts, and the zero-source clear. Set operand bits above bit 2 test that only the low three bits matter. After each instruction the bench compares the whole register file with a behavioural model.

// File: rtl/simd_perm_pkg.sv
`timescale 1ns/1ps
package simd_perm_pkg;
  localparam int WORD_W  = 32;
  localparam int LANE_W  = 8;
  localparam int REG_CNT = 16;
  localparam int RIDX_W  = $clog2(REG_CNT);

  localparam logic [2:0] SUB_ALIGN = 3'd1;
  localparam logic [2:0] SUB_LDIMM = 3'd3;

  typedef struct packed {
    logic [2:0]          sub;
    logic [RIDX_W-1:0]   dst;
    logic [RIDX_W-1:0]   src_b;
    logic [RIDX_W-1:0]   src_c;
    logic [LANE_W-1:0]   imm;
    logic [1:0]          pad;
    logic [2:0]          pat;
  } insn_fields_t;

  function automatic insn_fields_t split_insn(input logic [WORD_W-1:0] w);
    insn_fields_t f;
    f.sub   = w[20:18];
    f.dst   = w[9:6];
    f.src_b = w[13:10];
    f.src_c = w[17:14];
    f.imm   = w[17:10];
    f.pad   = w[22:21];
    f.pat   = w[25:23];
    return f;
  endfunction
endpackage

// File: rtl/imm_pattern_gen.sv
`timescale 1ns/1ps
module imm_pattern_gen #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic [LANE_W-1:0]       imm,
  input  logic [2:0]              pat,
  output logic [LANE_W*LANES-1:0] word
);
  localparam int WORD_W = LANE_W * LANES;
  logic [LANE_W-1:0] sign_byte;
  assign sign_byte = {LANE_W{imm[LANE_W-1]}};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic IS_ODD = logic'(k % 2);
    always_comb begin
      word[k*LANE_W +: LANE_W] = '0;
      unique case (pat)
        3'd0, 3'd1, 3'd2, 3'd3:
          if (int'(pat) == k) word[k*LANE_W +: LANE_W] = imm;
        3'd4:
          if (!IS_ODD) word[k*LANE_W +: LANE_W] = imm;
        3'd5:
          if (IS_ODD) word[k*LANE_W +: LANE_W] = imm;
        3'd6:
          word[k*LANE_W +: LANE_W] = IS_ODD ? sign_byte : imm;
        default:
          word[k*LANE_W +: LANE_W] = imm;
      endcase
    end
  end

  always_comb begin
    if (pat == 3'd7) begin
      // R4
      splat_all_chk: assert (word == {LANES{imm}});
    end
    if (pat == 3'd6) begin
      // R5
      half_splat_chk: assert (word[WORD_W-1:WORD_W/2] == word[WORD_W/2-1:0]);
    end
  end
endmodule

// File: rtl/byte_align_funnel.sv
`timescale 1ns/1ps
module byte_align_funnel #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0] hi,
  input  logic [LANE_W*LANES-1:0] lo,
  input  logic [2:0]              cnt,
  output logic [LANE_W*LANES-1:0] res,
  output logic                    cnt_ok
);
  localparam int WORD_W = LANE_W * LANES;
  logic [WORD_W-1:0] cand [LANES+1];

  for (genvar k = 0; k <= LANES; k++) begin : g_cand
    logic [2*WORD_W-1:0] shifted;
    assign shifted = {hi, lo} << (LANE_W * k);
    assign cand[k] = shifted[2*WORD_W-1 -: WORD_W];
  end

  always_comb begin
    res    = '0;
    cnt_ok = 1'b0;
    for (int k = 0; k <= LANES; k++) begin
      if (int'(cnt) == k) begin
        res    = cand[k];
        cnt_ok = 1'b1;
      end
    end
  end

  always_comb begin
    if (cnt == 3'd0) begin
      // R8
      n0_pass_b_chk: assert (res == hi);
    end
    if (int'(cnt) == LANES) begin
      // R8
      nmax_pass_c_chk: assert (res == lo);
    end
  end
endmodule

// File: rtl/xreg_file.sv
`timescale 1ns/1ps
module xreg_file #(
  parameter int REG_CNT = 16,
  parameter int WORD_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [$clog2(REG_CNT)-1:0] waddr,
  input  logic [WORD_W-1:0]          wdata,
  input  logic [$clog2(REG_CNT)-1:0] ra_b,
  input  logic [$clog2(REG_CNT)-1:0] ra_c,
  input  logic [$clog2(REG_CNT)-1:0] ra_d,
  output logic [WORD_W-1:0]          rd_b,
  output logic [WORD_W-1:0]          rd_c,
  output logic [WORD_W-1:0]          rd_d
);
  localparam int AW = $clog2(REG_CNT);
  logic [WORD_W-1:0] regs [REG_CNT];

  assign regs[0] = '0;

  for (genvar i = 1; i < REG_CNT; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (we && waddr == AW'(i))
        regs[i] <= wdata;
    end
  end

  assign rd_b = regs[ra_b];
  assign rd_c = regs[ra_c];
  assign rd_d = regs[ra_d];

  // R1
  zero_reg_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> waddr != '0);

  // R11
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> regs[REG_CNT-1] == '0 && regs[1] == '0);
endmodule

// File: rtl/simd_perm_unit.sv
`timescale 1ns/1ps
module simd_perm_unit
  import simd_perm_pkg::*;
#(
  parameter int LANES = WORD_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [WORD_W-1:0] insn_word,
  input  logic [WORD_W-1:0] gp_value,
  input  logic [RIDX_W-1:0] dbg_addr,
  output logic [WORD_W-1:0] dbg_data
);
  insn_fields_t      f;
  logic [WORD_W-1:0] src_b_val, src_c_val;
  logic [WORD_W-1:0] imm_word, aln_word;
  logic              aln_cnt_ok;
  logic              both_zero;
  logic              wr_en;
  logic [WORD_W-1:0] wr_data;

  assign f         = split_insn(insn_word);
  assign both_zero = (f.src_b == '0) && (f.src_c == '0);

  imm_pattern_gen #(.LANE_W(LANE_W), .LANES(LANES)) u_imm (
    .imm  (f.imm),
    .pat  (f.pat),
    .word (imm_word)
  );

  byte_align_funnel #(.LANE_W(LANE_W), .LANES(LANES)) u_aln (
    .hi     (src_b_val),
    .lo     (src_c_val),
    .cnt    (gp_value[2:0]),
    .res    (aln_word),
    .cnt_ok (aln_cnt_ok)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_data = '0;
    if (insn_valid && f.dst != '0) begin
      if (f.sub == SUB_LDIMM) begin
        if (f.pad == 2'b00) begin
          wr_en   = 1'b1;
          wr_data = imm_word;
        end
      end else if (f.sub == SUB_ALIGN) begin
        if (both_zero) begin
          wr_en   = 1'b1;
          wr_data = '0;
        end else if (aln_cnt_ok) begin
          wr_en   = 1'b1;
          wr_data = aln_word;
        end
      end
    end
  end

  xreg_file #(.REG_CNT(REG_CNT), .WORD_W(WORD_W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (f.dst),
    .wdata (wr_data),
    .ra_b  (f.src_b),
    .ra_c  (f.src_c),
    .ra_d  (dbg_addr),
    .rd_b  (src_b_val),
    .rd_c  (src_c_val),
    .rd_d  (dbg_data)
  );

  // R2
  other_sub_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (f.sub != SUB_ALIGN && f.sub != SUB_LDIMM) || !insn_valid |-> !wr_en);

  // R6
  pad_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && f.sub == SUB_LDIMM && f.pad != 2'b00) |-> !wr_en);

  // R9
  undef_cnt_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && f.sub == SUB_ALIGN && gp_value[2:0] > 3'd4 && !both_zero) |-> !wr_en);

  // R10
  zero_src_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && f.sub == SUB_ALIGN && both_zero && f.dst != '0)
      |=> u_rf.regs[$past(f.dst)] == '0);
endmodule

// File: tb/simd_perm_unit_test.sv
`timescale 1ns/1ps
module simd_perm_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic [31:0] gp_value = '0;
  logic [3:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] model [16];

  always #4 clk = ~clk;

  simd_perm_unit uut (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .gp_value(gp_value), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  function automatic logic [31:0] enc_imm(int dst, int s8, int pad, int pat);
    return {6'b0, 3'(pat), 2'(pad), 3'd3, 8'(s8), 4'(dst), 6'b0};
  endfunction

  function automatic logic [31:0] enc_aln(int dst, int b, int c, int rs);
    return {6'b0, 5'(rs), 3'd1, 4'(c), 4'(b), 4'(dst), 6'b0};
  endfunction

  // behavioural reference
  task automatic model_apply(input bit v, input logic [31:0] w, input logic [31:0] g);
    int d, b, c, n, pat;
    logic [7:0] s;
    logic [15:0] hw;
    longint unsigned pair;
    if (!v) return;
    d = int'(w[9:6]);
    if (d == 0) return;
    if (w[20:18] == 3'd3 && w[22:21] == 2'd0) begin
      s = w[17:10];
      pat = int'(w[25:23]);
      case (pat)
        0, 1, 2, 3: model[d] = 32'(s) << (8 * pat);
        4: model[d] = 32'(s) * 32'h0001_0001;
        5: model[d] = 32'(s) * 32'h0100_0100;
        6: begin hw = 16'(signed'(s)); model[d] = {hw, hw}; end
        default: model[d] = 32'(s) * 32'h0101_0101;
      endcase
    end else if (w[20:18] == 3'd1) begin
      b = int'(w[13:10]);
      c = int'(w[17:14]);
      n = int'(g[2:0]);
      if (b == 0 && c == 0) model[d] = 0;
      else if (n <= 4) begin
        pair = {model[b], model[c]};
        pair = pair << (8 * n);
        model[d] = pair[63:32];
      end
    end
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 16; a++) begin
      dbg_addr = 4'(a);
      #0.2;
      total++;
      if (dbg_data !== model[a]) begin
        bad++;
        $display("FAIL %s reg%0d actual=%h expected=%h", req, a, dbg_data, model[a]);
      end
    end
  endtask

  task automatic issue(input bit v, input logic [31:0] w, input logic [31:0] g, input string req);
    @(negedge clk);
    insn_valid = v;
    insn_word = w;
    gp_value = g;
    @(negedge clk);
    insn_valid = 1'b0;
    model_apply(v, w, g);
    sweep(req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    sweep("R1 reset");

    // R3 single-lane placement
    issue(1, enc_imm(1, 8'hA7, 0, 0), 0, "R3 pat0");
    issue(1, enc_imm(2, 8'h3C, 0, 1), 0, "R3 pat1");
    issue(1, enc_imm(3, 8'hF1, 0, 2), 0, "R3 pat2");
    issue(1, enc_imm(4, 8'h81, 0, 3), 0, "R3 pat3");
    // R4 replication
    issue(1, enc_imm(5, 8'h5A, 0, 4), 0, "R4 pat4");
    issue(1, enc_imm(6, 8'hC3, 0, 5), 0, "R4 pat5");
    issue(1, enc_imm(7, 8'h96, 0, 7), 0, "R4 pat7");
    // R5 sign-extended halfword
    issue(1, enc_imm(8, 8'h85, 0, 6), 0, "R5 pat6 negative");
    issue(1, enc_imm(9, 8'h7F, 0, 6), 0, "R5 pat6 positive");
    // R6 drop cases
    issue(1, enc_imm(1, 8'hEE, 1, 7), 0, "R6 pad");
    issue(1, enc_imm(2, 8'hEE, 3, 0), 0, "R6 pad3");
    issue(1, enc_imm(0, 8'hEE, 0, 7), 0, "R6 dst0");
    // R2 other sub-opcodes and invalid strobe
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 3) continue;
      w = enc_imm(3, 8'h11, 0, 7);
      w[20:18] = 3'(s);
      issue(1, w, 32'h2, "R2 other sub");
    end
    issue(0, enc_imm(4, 8'h22, 0, 7), 0, "R2 invalid strobe");
    issue(0, enc_aln(5, 7, 8, 0), 1, "R2 invalid strobe align");
    // R7 funnel n=1..3, high operand bits set
    issue(1, enc_aln(10, 7, 8, 3), 32'hFFFF_FFF1, "R7 n1");
    issue(1, enc_aln(11, 5, 6, 9), 32'h0000_0A02, "R7 n2");
    issue(1, enc_aln(12, 1, 8, 2), 32'h8000_0003, "R7 n3");
    // R8 endpoints
    issue(1, enc_aln(13, 6, 8, 0), 32'hF0, "R8 n0");
    issue(1, enc_aln(14, 6, 8, 0), 32'h1C, "R8 n4");
    issue(1, enc_aln(13, 0, 7, 0), 32'h3, "R7 b zero");
    // R9 undefined counts and dst 0
    issue(1, enc_aln(10, 7, 8, 0), 32'h5, "R9 n5");
    issue(1, enc_aln(11, 7, 8, 0), 32'h6, "R9 n6");
    issue(1, enc_aln(12, 7, 8, 0), 32'hF, "R9 n7");
    issue(1, enc_aln(0, 7, 8, 0), 32'h1, "R9 dst0");
    // R10 zero sources clear for every n
    for (int n = 0; n < 8; n++) begin
      issue(1, enc_imm(15, 8'h6D, 0, 7), 0, "R11 refill");
      issue(1, enc_aln(15, 0, 0, 0), 32'(n), "R10 zero sources");
    end
    // R11 back-to-back writes
    @(negedge clk);
    insn_valid = 1'b1; insn_word = enc_imm(9, 8'h12, 0, 7); gp_value = 0;
    @(negedge clk);
    model_apply(1, insn_word, 0);
    insn_word = enc_aln(10, 9, 9, 0); gp_value = 32'h1;
    @(negedge clk);
    insn_valid = 1'b0;
    model_apply(1, insn_word, gp_value);
    sweep("R11 back-to-back");

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      w = $urandom;
      case ($urandom % 4)
        0: begin w[20:18] = 3'd3; if ($urandom % 4 != 0) w[22:21] = 2'd0; end
        1, 2: w[20:18] = 3'd1;
        default: ;
      endcase
      issue(($urandom % 8) != 0, w, $urandom, "R2 R7 R9 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule